// File: doc/BRIEF.md
# I2C Master Addressing Sequencer

This block is the transaction-level controller of an I2C master. A requester presents a 16-bit address word, a read/write flag and a byte count, then pulses start. The sequencer runs the address phase and the data phase by handing one command at a time to a byte-level I2C engine. The commands are START, repeated START, write byte, read byte with ACK, read byte with NACK, and STOP. Before it issues the next command, the sequencer waits for the engine's completion strobe and, after a write, for its acknowledge-received flag.

Bit 15 of the address word selects the addressing mode. When it is clear, one 7-bit address byte follows START. When it is set, the block uses 10-bit addressing: a header byte, then the low address byte. A 10-bit read then adds a repeated START and the header again with the read bit set. Payload bytes for writes come from a valid/ready source. Received bytes go to a sink as one-cycle strobes. A missing acknowledge on any address byte or written byte ends the transaction with STOP and an error pulse.

Top module: `i2c_addr_seq`

## Requirements
- R1: Commands appear on `cmd_o` with a one-cycle `cmd_valid_o` pulse, using these codes: 0 START, 1 repeated START, 2 write byte (`cmd_data_o` holds the byte), 3 read with ACK, 4 read with NACK, 5 STOP. No command is issued until `eng_done_i` has answered the previous one. Every transaction opens with START and closes with STOP.
- R2: When `addr_i[15]` is 0, the byte written after START is `{addr[6:0], rd}`.
- R3: When `addr_i[15]` is 1, the byte written after START is `{5'b11110, addr[9:8], 1'b0}`. Once that byte is acknowledged, the next byte written is `addr[7:0]`.
- R4: For a 10-bit write, once the low address byte is acknowledged, the next command is the write of the first payload byte. No repeated START is issued.
- R5: For a 10-bit read, once the low address byte is acknowledged, the block issues a repeated START. It then writes `{5'b11110, addr[9:8], 1'b1}` and issues reads only after that byte is acknowledged.
- R6: In the receive phase, every read except the last uses code 3 and the last uses code 4. `ack_en_o` is high while a code-3 read is issued and low while a code-4 read is issued. It therefore goes high on entering the receive phase only when more than one byte is requested.
- R7: After the final read completes, the next command is STOP. When the STOP completes, `done_o` pulses. Each received byte appears on `rx_data_o` with a one-cycle `rx_valid_o` pulse, in the order received.
- R8: Payload bytes are taken through the `tx_valid_i`/`tx_ready_o` handshake and written in arrival order. After the last byte is acknowledged, STOP is issued and `done_o` pulses when it completes.
- R9: If any address byte or payload byte completes with `eng_ack_i` low, the next command is STOP. `err_o` pulses when that STOP completes, `done_o` does not pulse, and no further command follows.
- R10: A byte count of 0 runs the complete address phase and then goes straight to STOP and `done_o`.
- R11: `busy_o` rises in the cycle after an accepted start and falls in the cycle after the STOP completes. A start pulse while `busy_o` is high has no effect, including one in the cycle where the STOP completes.
- R12: During and after reset, `busy_o`, `cmd_valid_o`, `done_o`, `err_o`, `rx_valid_o` and `tx_ready_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| addr_i | input | 16 | Address word; bit 15 selects 10-bit mode |
| rd_i | input | 1 | 1 = read, 0 = write |
| len_i | input | LEN_W | Number of payload bytes |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | Pulse: transaction finished normally |
| err_o | output | 1 | Pulse: transaction ended on a NACK |
| cmd_valid_o | output | 1 | Command strobe to the byte engine |
| cmd_o | output | 3 | Command code |
| cmd_data_o | output | 8 | Byte for a write command |
| eng_done_i | input | 1 | Engine finished the current command |
| eng_ack_i | input | 1 | Slave acknowledged the written byte |
| eng_rdata_i | input | 8 | Byte read by the engine |
| ack_en_o | output | 1 | Master acknowledge enabled for reads |
| tx_data_i | input | 8 | Payload byte from the source |
| tx_valid_i | input | 1 | Source byte valid |
| tx_ready_o | output | 1 | Sequencer accepts a payload byte |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |

## Verification
Two functions can land in the same cycle. The engine's completion of the closing STOP can coincide with a fresh start request on `start_i`. At that moment the sequencer is still busy and must drop the request, yet it still has to finish the transaction with its own done pulse. The bench provokes this by having its engine model raise `start_i` in exactly the cycle it answers a STOP. It then judges the outcome from the command log: the log must match the single transaction exactly, no new START may appear in the idle cycles that follow, and `busy_o` must end low.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    CMD_START   = 3'd0,
    CMD_RESTART = 3'd1,
    CMD_WRITE   = 3'd2,
    CMD_RD_ACK  = 3'd3,
    CMD_RD_NACK = 3'd4,
    CMD_STOP    = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    ST_READY,
    ST_START,
    ST_HS10,
    ST_ADDR,
    ST_TX,
    ST_RX,
    ST_FIN,
    ST_ERR
  } st_e;

  localparam logic [4:0] HDR10 = 5'b11110;
endpackage

// File: rtl/i2c_addr_fmt.sv
module i2c_addr_fmt
  import i2c_seq_pkg::*;
(
  input  logic [15:0] addr_i,
  input  logic        rd_i,
  output logic        is10_o,
  output logic [7:0]  a7_o,
  output logic [7:0]  hdr_wr_o,
  output logic [7:0]  hdr_rd_o,
  output logic [7:0]  lo_o
);
  logic unused_bits;
  assign unused_bits = ^addr_i[14:10];

  assign is10_o   = addr_i[15];
  assign a7_o     = {addr_i[6:0], rd_i};
  assign hdr_wr_o = {HDR10, addr_i[9:8], 1'b0};
  assign hdr_rd_o = {HDR10, addr_i[9:8], 1'b1};
  assign lo_o     = addr_i[7:0];
endmodule

// File: rtl/i2c_seq_cnt.sv
module i2c_seq_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o,
  output logic         last_o,
  output logic         gt2_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= val_i;
    else if (dec_i && cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == W'(1));
  assign gt2_o  = (cnt_q > W'(2));
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [15:0] addr_i,
  input  logic        rd_i,
  output logic [15:0] req_addr_o,
  output logic        req_rd_o,
  input  logic        is10_i,
  input  logic [7:0]  a7_i,
  input  logic [7:0]  hdr_wr_i,
  input  logic [7:0]  hdr_rd_i,
  input  logic [7:0]  lo_i,
  output logic        cnt_load_o,
  output logic        cnt_dec_o,
  input  logic        cnt_zero_i,
  input  logic        cnt_last_i,
  input  logic        cnt_gt2_i,
  input  logic        eng_done_i,
  input  logic        eng_ack_i,
  input  logic [7:0]  eng_rdata_i,
  output cmd_e        cmd_o,
  output logic        cmd_valid_o,
  output logic [7:0]  cmd_data_o,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_valid_i,
  output logic        tx_ready_o,
  output logic [7:0]  rx_data_o,
  output logic        rx_valid_o,
  output logic        ack_en_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);
  st_e         st_q, st_d;
  logic        pend_q, pend_d;
  logic [1:0]  hs_q, hs_d;
  logic        ack_en_q, ack_en_d;
  logic [15:0] addr_q;
  logic        rd_q;
  logic        latch;
  logic        issue;
  cmd_e        icmd;
  logic [7:0]  idata;
  logic        done_d, err_d, rxv_d;

  // next phase once addressing is acknowledged
  function automatic st_e data_phase(input logic rd, input logic zero);
    if (zero)    return ST_FIN;
    else if (rd) return ST_RX;
    else         return ST_TX;
  endfunction

  always_comb begin
    st_d       = st_q;
    pend_d     = pend_q;
    hs_d       = hs_q;
    ack_en_d   = ack_en_q;
    latch      = 1'b0;
    issue      = 1'b0;
    icmd       = CMD_STOP;
    idata      = '0;
    done_d     = 1'b0;
    err_d      = 1'b0;
    rxv_d      = 1'b0;
    cnt_load_o = 1'b0;
    cnt_dec_o  = 1'b0;
    tx_ready_o = 1'b0;
    unique case (st_q)
      ST_READY: begin
        if (start_i) begin
          latch      = 1'b1;
          cnt_load_o = 1'b1;
          pend_d     = 1'b0;
          hs_d       = 2'd0;
          ack_en_d   = 1'b0;
          st_d       = ST_START;
        end
      end
      ST_START: begin
        if (!pend_q) begin
          issue  = 1'b1;
          icmd   = CMD_START;
          pend_d = 1'b1;
        end else if (eng_done_i) begin
          pend_d = 1'b0;
          hs_d   = 2'd0;
          st_d   = is10_i ? ST_HS10 : ST_ADDR;
        end
      end
      ST_HS10: begin
        if (!pend_q) begin
          issue  = 1'b1;
          pend_d = 1'b1;
          unique case (hs_q)
            2'd0:    begin icmd = CMD_WRITE; idata = hdr_wr_i; end
            2'd1:    begin icmd = CMD_WRITE; idata = lo_i;     end
            default: icmd = CMD_RESTART;
          endcase
        end else if (eng_done_i) begin
          pend_d = 1'b0;
          if (hs_q != 2'd2 && !eng_ack_i) st_d = ST_ERR;
          else if (hs_q == 2'd0)          hs_d = 2'd1;
          else if (hs_q == 2'd1) begin
            if (rd_q) hs_d = 2'd2;
            else      st_d = data_phase(1'b0, cnt_zero_i);
          end else    st_d = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (!pend_q) begin
          issue  = 1'b1;
          pend_d = 1'b1;
          icmd   = CMD_WRITE;
          idata  = is10_i ? hdr_rd_i : a7_i;
        end else if (eng_done_i) begin
          pend_d = 1'b0;
          if (!eng_ack_i) st_d = ST_ERR;
          else begin
            st_d = data_phase(rd_q, cnt_zero_i);
            if (rd_q) ack_en_d = !cnt_zero_i && !cnt_last_i;
          end
        end
      end
      ST_TX: begin
        if (!pend_q) begin
          tx_ready_o = 1'b1;
          if (tx_valid_i) begin
            issue  = 1'b1;
            pend_d = 1'b1;
            icmd   = CMD_WRITE;
            idata  = tx_data_i;
          end
        end else if (eng_done_i) begin
          pend_d = 1'b0;
          if (!eng_ack_i) st_d = ST_ERR;
          else begin
            cnt_dec_o = 1'b1;
            if (cnt_last_i) st_d = ST_FIN;
          end
        end
      end
      ST_RX: begin
        if (!pend_q) begin
          issue  = 1'b1;
          pend_d = 1'b1;
          icmd   = ack_en_q ? CMD_RD_ACK : CMD_RD_NACK;
        end else if (eng_done_i) begin
          pend_d    = 1'b0;
          rxv_d     = 1'b1;
          cnt_dec_o = 1'b1;
          ack_en_d  = cnt_gt2_i;
          if (cnt_last_i) st_d = ST_FIN;
        end
      end
      ST_FIN, ST_ERR: begin
        if (!pend_q) begin
          issue  = 1'b1;
          pend_d = 1'b1;
          icmd   = CMD_STOP;
        end else if (eng_done_i) begin
          pend_d   = 1'b0;
          ack_en_d = 1'b0;
          done_d   = (st_q == ST_FIN);
          err_d    = (st_q == ST_ERR);
          st_d     = ST_READY;
        end
      end
      default: st_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_READY;
      pend_q      <= 1'b0;
      hs_q        <= 2'd0;
      ack_en_q    <= 1'b0;
      addr_q      <= '0;
      rd_q        <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_o       <= CMD_START;
      cmd_data_o  <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      rx_valid_o  <= 1'b0;
      rx_data_o   <= '0;
    end else begin
      st_q        <= st_d;
      pend_q      <= pend_d;
      hs_q        <= hs_d;
      ack_en_q    <= ack_en_d;
      cmd_valid_o <= issue;
      done_o      <= done_d;
      err_o       <= err_d;
      rx_valid_o  <= rxv_d;
      if (latch) begin
        addr_q <= addr_i;
        rd_q   <= rd_i;
      end
      if (issue) begin
        cmd_o      <= icmd;
        cmd_data_o <= idata;
      end
      if (rxv_d) rx_data_o <= eng_rdata_i;
    end
  end

  assign req_addr_o = addr_q;
  assign req_rd_o   = rd_q;
  assign ack_en_o   = ack_en_q;
  assign busy_o     = (st_q != ST_READY);
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [15:0]      addr_i,
  input  logic             rd_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             cmd_valid_o,
  output logic [2:0]       cmd_o,
  output logic [7:0]       cmd_data_o,
  input  logic             eng_done_i,
  input  logic             eng_ack_i,
  input  logic [7:0]       eng_rdata_i,
  output logic             ack_en_o,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o
);
  logic [15:0] req_addr;
  logic        req_rd;
  logic        is10;
  logic [7:0]  a7, hdr_wr, hdr_rd, lo;
  logic        cnt_load, cnt_dec, cnt_zero, cnt_last, cnt_gt2;
  cmd_e        cmd;

  i2c_addr_fmt u_fmt (
    .addr_i   (req_addr),
    .rd_i     (req_rd),
    .is10_o   (is10),
    .a7_o     (a7),
    .hdr_wr_o (hdr_wr),
    .hdr_rd_o (hdr_rd),
    .lo_o     (lo)
  );

  i2c_seq_cnt #(.W(LEN_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (len_i),
    .dec_i  (cnt_dec),
    .zero_o (cnt_zero),
    .last_o (cnt_last),
    .gt2_o  (cnt_gt2)
  );

  i2c_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .addr_i      (addr_i),
    .rd_i        (rd_i),
    .req_addr_o  (req_addr),
    .req_rd_o    (req_rd),
    .is10_i      (is10),
    .a7_i        (a7),
    .hdr_wr_i    (hdr_wr),
    .hdr_rd_i    (hdr_rd),
    .lo_i        (lo),
    .cnt_load_o  (cnt_load),
    .cnt_dec_o   (cnt_dec),
    .cnt_zero_i  (cnt_zero),
    .cnt_last_i  (cnt_last),
    .cnt_gt2_i   (cnt_gt2),
    .eng_done_i  (eng_done_i),
    .eng_ack_i   (eng_ack_i),
    .eng_rdata_i (eng_rdata_i),
    .cmd_o       (cmd),
    .cmd_valid_o (cmd_valid_o),
    .cmd_data_o  (cmd_data_o),
    .tx_data_i   (tx_data_i),
    .tx_valid_i  (tx_valid_i),
    .tx_ready_o  (tx_ready_o),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o),
    .ack_en_o    (ack_en_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  assign cmd_o = cmd;
endmodule

// File: rtl/i2c_addr_seq_chk.sv
module i2c_addr_seq_chk
  import i2c_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       cmd_valid_o,
  input logic [2:0] cmd_o,
  input logic       done_o,
  input logic       err_o,
  input logic       rx_valid_o
);
  logic       seen_q;
  logic [2:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= CMD_STOP;
    end else if (cmd_valid_o) begin
      seen_q <= 1'b1;
      last_q <= cmd_o;
    end
  end

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o);

  a_r1_start_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == CMD_START) |-> (!seen_q || last_q == CMD_STOP));

  a_r5_restart_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == CMD_RESTART) |-> (seen_q && last_q == CMD_WRITE));

  a_r7_nack_then_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && seen_q && last_q == CMD_RD_NACK) |-> cmd_o == CMD_STOP);

  a_r7_rx_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (seen_q && (last_q == CMD_RD_ACK || last_q == CMD_RD_NACK)));

  a_r8_done_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (seen_q && last_q == CMD_STOP && !err_o));

  a_r9_err_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (seen_q && last_q == CMD_STOP));
endmodule

bind i2c_addr_seq i2c_addr_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_o       (cmd_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .rx_valid_o  (rx_valid_o)
);

// File: tb/i2c_addr_seq_test.sv
module i2c_addr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NONE = 31;

  localparam logic [2:0] C_START = 3'd0, C_RS = 3'd1, C_WR = 3'd2,
                         C_RA = 3'd3, C_RN = 3'd4, C_STOP = 3'd5;

  typedef struct packed {
    logic [15:0] addr;
    logic        rd;
    logic [7:0]  len;
    logic [4:0]  nk;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'h0050, 1'b0, 8'd3, 5'd31},
    '{16'h0023, 1'b1, 8'd2, 5'd31},
    '{16'h82A5, 1'b0, 8'd2, 5'd31},
    '{16'h8344, 1'b1, 8'd3, 5'd31},
    '{16'h8112, 1'b1, 8'd1, 5'd31},
    '{16'h007E, 1'b1, 8'd1, 5'd31},
    '{16'h0011, 1'b0, 8'd2, 5'd1},
    '{16'h8200, 1'b0, 8'd2, 5'd1},
    '{16'h8255, 1'b1, 8'd2, 5'd2},
    '{16'h0033, 1'b0, 8'd3, 5'd3},
    '{16'h0042, 1'b0, 8'd0, 5'd31},
    '{16'h8101, 1'b1, 8'd2, 5'd4},
    '{16'h83C7, 1'b1, 8'd0, 5'd31}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_ni, start_i, start_drv, coll_start;
  logic [15:0] addr_i;
  logic        rd_i;
  logic [7:0]  len_i;
  logic        busy_o, done_o, err_o, cmd_valid_o, ack_en_o;
  logic [2:0]  cmd_o;
  logic [7:0]  cmd_data_o;
  logic        eng_done_i, eng_ack_i;
  logic [7:0]  eng_rdata_i, tx_data_i, rx_data_o;
  logic        tx_valid_i, tx_ready_o, rx_valid_o;

  assign start_i = start_drv | coll_start;

  i2c_addr_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .rd_i(rd_i), .len_i(len_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o),
    .cmd_data_o(cmd_data_o), .eng_done_i(eng_done_i), .eng_ack_i(eng_ack_i),
    .eng_rdata_i(eng_rdata_i), .ack_en_o(ack_en_o), .tx_data_i(tx_data_i),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .rx_data_o(rx_data_o),
    .rx_valid_o(rx_valid_o)
  );

  int n_tests = 0, n_fail = 0;
  bit reported = 0;

  logic [2:0] lc [64];
  logic [7:0] ld [64];
  logic       la [64];
  int         nl;
  logic [7:0] rxl [32];
  int         nrx, ndone, nerr;
  int         nack_at = -1;
  int         tx_idx;
  bit         coll_en = 0;

  logic [2:0] ec [64];
  logic [7:0] ed [64];
  string      er [64];
  int         ne;
  logic [7:0] erx [32];
  int         nerx;
  bit         eerr, cut;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
  endtask

  // byte engine model: answers each command two cycles later
  initial begin
    int wt;
    wt = 0;
    eng_done_i = 0; eng_ack_i = 0; eng_rdata_i = 0; coll_start = 0;
    forever begin
      @(negedge clk);
      eng_done_i = 0;
      coll_start = 0;
      if (wt == 1) begin
        eng_done_i  = 1;
        eng_ack_i   = ((nl - 1) != nack_at);
        eng_rdata_i = 8'(8'hA0 + nl - 1);
        if (coll_en && nl > 0 && nl <= 64 && lc[nl-1] == C_STOP) coll_start = 1;
      end
      if (wt != 0) wt--;
      if (cmd_valid_o) begin
        if (nl < 64) begin
          lc[nl] = cmd_o; ld[nl] = cmd_data_o; la[nl] = ack_en_o;
        end
        nl++;
        wt = 2;
      end
      if (rx_valid_o) begin
        if (nrx < 32) rxl[nrx] = rx_data_o;
        nrx++;
      end
      if (done_o) ndone++;
      if (err_o)  nerr++;
    end
  end

  // payload source
  initial begin
    bit hs;
    hs = 0;
    tx_data_i = 0;
    forever begin
      @(negedge clk);
      if (hs) tx_idx++;
      tx_data_i = 8'(8'h30 + tx_idx);
      hs = tx_valid_i && tx_ready_o;
    end
  end

  task automatic push(input logic [2:0] c, input logic [7:0] d, input string r, input int nk);
    if (!cut) begin
      if (c == C_RA || c == C_RN) begin
        erx[nerx] = 8'(8'hA0 + ne);
        nerx++;
      end
      ec[ne] = c; ed[ne] = d; er[ne] = r; ne++;
      if (c == C_WR && ne - 1 == nk) begin
        cut = 1; eerr = 1;
        ec[ne] = C_STOP; ed[ne] = 0; er[ne] = "R9"; ne++;
      end
    end
  endtask

  task automatic build(input vec_t v);
    int nk;
    nk = (v.nk == 5'(NONE)) ? -1 : int'(v.nk);
    ne = 0; nerx = 0; eerr = 0; cut = 0;
    push(C_START, 0, "R1", nk);
    if (!v.addr[15]) push(C_WR, {v.addr[6:0], v.rd}, "R2", nk);
    else begin
      push(C_WR, {5'b11110, v.addr[9:8], 1'b0}, "R3", nk);
      push(C_WR, v.addr[7:0], "R3", nk);
      if (v.rd) begin
        push(C_RS, 0, "R5", nk);
        push(C_WR, {5'b11110, v.addr[9:8], 1'b1}, "R5", nk);
      end
    end
    for (int i = 0; i < int'(v.len); i++) begin
      if (v.rd) push((i < int'(v.len) - 1) ? C_RA : C_RN, 0, "R6", nk);
      else      push(C_WR, 8'(8'h30 + i), v.addr[15] ? "R4" : "R8", nk);
    end
    if (!cut) push(C_STOP, 0, (v.len == 0) ? "R10" : (v.rd ? "R7" : "R8"), nk);
  endtask

  task automatic run(input vec_t v, input bit coll, input bit mid);
    int t;
    string rq;
    @(negedge clk);
    nl = 0; nrx = 0; ndone = 0; nerr = 0; tx_idx = 0;
    nack_at = (v.nk == 5'(NONE)) ? -1 : int'(v.nk);
    coll_en = coll;
    addr_i = v.addr; rd_i = v.rd; len_i = v.len;
    start_drv = 1;
    @(negedge clk);
    start_drv = 0;
    chk("R11", "busy after start", int'(busy_o), 1);
    t = 0;
    while (busy_o && t < 4000) begin
      @(negedge clk);
      t++;
      if (mid && t == 10) begin
        addr_i = 16'h0077; rd_i = 1'b1; start_drv = 1;
      end else start_drv = 0;
    end
    start_drv = 0;
    if (t >= 4000) chk("R11", "transaction timeout", 1, 0);
    repeat (5) @(negedge clk);
    chk("R11", "busy after stop", int'(busy_o), 0);
    build(v);
    rq = eerr ? "R9" : ((v.len == 0) ? "R10" : "R1");
    chk(rq, "command count", nl, ne);
    for (int i = 0; i < ne && i < nl && i < 64; i++) begin
      chk(er[i], $sformatf("cmd %0d code", i), int'(lc[i]), int'(ec[i]));
      if (ec[i] == C_WR) chk(er[i], $sformatf("cmd %0d data", i), int'(ld[i]), int'(ed[i]));
      if (ec[i] == C_RA || ec[i] == C_RN)
        chk("R6", $sformatf("cmd %0d ack_en", i), int'(la[i]), int'(ec[i] == C_RA));
    end
    chk("R7", "rx count", nrx, nerx);
    for (int i = 0; i < nerx && i < nrx && i < 32; i++)
      chk("R7", $sformatf("rx byte %0d", i), int'(rxl[i]), int'(erx[i]));
    chk(eerr ? "R9" : (v.len == 0 ? "R10" : (v.rd ? "R7" : "R8")), "done pulses", ndone, eerr ? 0 : 1);
    chk("R9", "err pulses", nerr, eerr ? 1 : 0);
    coll_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    rst_ni = 0; start_drv = 0; addr_i = 0; rd_i = 0; len_i = 0; tx_valid_i = 0;
    nl = 0; nrx = 0; ndone = 0; nerr = 0; tx_idx = 0;
    repeat (3) @(negedge clk);
    chk("R12", "busy in reset", int'(busy_o), 0);
    chk("R12", "cmd_valid in reset", int'(cmd_valid_o), 0);
    chk("R12", "done/err in reset", int'(done_o | err_o), 0);
    chk("R12", "rx_valid/tx_ready in reset", int'(rx_valid_o | tx_ready_o), 0);
    rst_ni = 1;
    tx_valid_i = 1;
    repeat (2) @(negedge clk);
    chk("R12", "busy after reset", int'(busy_o), 0);
    chk("R12", "no command after reset", nl, 0);
    for (int i = 0; i < NV; i++) run(VECS[i], 1'b0, 1'b0);
    // R11: start collides with STOP completion
    run(VECS[0], 1'b1, 1'b0);
    run(VECS[3], 1'b1, 1'b0);
    // R11: start in the middle of a transaction
    run(VECS[2], 1'b0, 1'b1);
    report();
    $finish;
  end
endmodule